// File: doc/BRIEF.md
# Power-Fail Store/Recall Sequencer

This block sequences a battery-free nonvolatile SRAM through its power events. A comparator outside the block gives a digital supply-good flag. When the flag first rises, the sequencer issues a recall pulse to the nonvolatile array. It then keeps host access closed for a timed recall window. When the window ends, host reads and writes pass through to the SRAM.

When the supply-good flag falls, the sequencer checks whether the SRAM has been written since the last store or recall. If it has, a short grace window lets an in-flight host cycle finish. The sequencer then cuts access, pulses the array to store, and pulls the open-drain handshake line low for the timed store window. After the store, the line is driven high for a short hold time and then released to its weak pull-up. If the SRAM is clean, no store takes place and access is simply cut.

A brown-out whose supply recovers is treated like a fresh power-up. Any pending store finishes first, and a full recall follows before access reopens. A second flag shows that the supply is too low to power the handshake driver, and it turns that driver off. All durations are clock-cycle counts given as parameters.

Top module: `nvsram_pwr_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, status reads inhibited (4), both memory enables are low whatever the host drives, the handshake driver is off and no store or recall pulse is issued.
- R2: When supply-good rises while the status is inhibited, status becomes recall (1) one clock edge later and stays there for RECALL_CYC cycles. The recall pulse is high only in the first of those cycles. Status then becomes idle (0).
- R3: In idle with supply-good high, the memory read and write enables equal the host read and write strobes in the same cycle.
- R4: Memory read and write enables stay low in recall, store (3) and inhibited states, whatever the host drives.
- R5: A write that reaches the SRAM marks it dirty. A store or recall that runs to completion marks it clean.
- R6: When supply-good falls in idle and the SRAM is dirty, status goes to grace (2) for GRACE_CYC cycles with both enables following the host. It then goes to store for STORE_CYC cycles, and the store pulse is high only in the first of those cycles.
- R7: When supply-good falls in idle and the SRAM is clean, status goes straight to inhibited. No store pulse is issued and the handshake line is never driven low.
- R8: During store with the driver-supply flag high, the handshake driver is enabled and drives low.
- R9: For HOLD_CYC cycles after a store ends, the handshake driver is enabled and drives high. After that it is released.
- R10: While the driver-supply flag is low, the handshake driver is disabled.
- R11: A store, once entered, runs to completion even if the supply recovers. Once the store ends, a high supply-good starts a new full recall. If supply-good falls during a recall, the recall is abandoned and status returns to inhibited.
- R12: Status carries the state code: idle 0, recall 1, grace 2, store 3, inhibited 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply above the store/recall trigger level |
| drv_supply_ok | input | 1 | Supply high enough to power the handshake driver |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| mem_rd_en | output | 1 | Gated read enable to the SRAM |
| mem_wr_en | output | 1 | Gated write enable to the SRAM |
| hsk_oe | output | 1 | Handshake line driver enable (open drain when low) |
| hsk_drv | output | 1 | Level the handshake driver puts on the line when enabled |
| store_pulse | output | 1 | One-cycle command: copy SRAM into the nonvolatile cells |
| recall_pulse | output | 1 | One-cycle command: copy the nonvolatile cells into SRAM |
| status | output | 3 | Current state code |

## Verification
The gated enables and the handshake outputs are combinational on the registered state. They respond in the same cycle as a host strobe or a change in the driver-supply flag. A supply-good edge shows up on status and on the pulses one clock edge later. Each timed window then lasts exactly its parameter count in cycles. The hold window starts on the edge that ends the store. The bench drives inputs just after the falling edge and compares every output a moment later against a behavioural model that is advanced on each rising edge. Every cycle's result is therefore checked in the cycle in which it is due.

// File: rtl/nvps_pkg.sv
package nvps_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_RECALL  = 3'd1,
        ST_GRACE   = 3'd2,
        ST_STORE   = 3'd3,
        ST_INHIBIT = 3'd4
    } seq_state_e;

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/nvps_fsm.sv
module nvps_fsm
    import nvps_pkg::*;
#(
    parameter int unsigned RECALL_CYC = 4000000,
    parameter int unsigned STORE_CYC  = 1600000,
    parameter int unsigned GRACE_CYC  = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       supply_ok,
    input  logic       wr_taken,
    output seq_state_e state_o,
    output logic       store_done_o,
    output logic       store_pulse_o,
    output logic       recall_pulse_o
);

    localparam int unsigned LONGEST = max3(RECALL_CYC, STORE_CYC, GRACE_CYC);
    localparam int unsigned CW      = $clog2(LONGEST + 1);

    typedef struct packed {
        seq_state_e      st;
        logic [CW-1:0]   cnt;
        logic            dirty;
        logic            sp;
        logic            rp;
    } fsm_t;

    fsm_t r_d, r_q;
    logic cnt_zero;

    assign cnt_zero = (r_q.cnt == '0);

    always_comb begin
        r_d    = r_q;
        r_d.sp = 1'b0;
        r_d.rp = 1'b0;
        if (!r_q.cnt[CW-1] || r_q.cnt != '0) begin
            r_d.cnt = cnt_zero ? '0 : r_q.cnt - 1'b1;
        end
        unique case (r_q.st)
            ST_INHIBIT: begin
                if (supply_ok) begin
                    r_d.st  = ST_RECALL;
                    r_d.cnt = CW'(RECALL_CYC - 1);
                    r_d.rp  = 1'b1;
                end
            end
            ST_RECALL: begin
                if (!supply_ok) begin
                    r_d.st = ST_INHIBIT;
                end else if (cnt_zero) begin
                    r_d.st    = ST_IDLE;
                    r_d.dirty = 1'b0;
                end
            end
            ST_IDLE: begin
                if (wr_taken) begin
                    r_d.dirty = 1'b1;
                end
                if (!supply_ok) begin
                    if (r_q.dirty) begin
                        r_d.st  = ST_GRACE;
                        r_d.cnt = CW'(GRACE_CYC - 1);
                    end else begin
                        r_d.st = ST_INHIBIT;
                    end
                end
            end
            ST_GRACE: begin
                if (wr_taken) begin
                    r_d.dirty = 1'b1;
                end
                if (cnt_zero) begin
                    r_d.st  = ST_STORE;
                    r_d.cnt = CW'(STORE_CYC - 1);
                    r_d.sp  = 1'b1;
                end
            end
            ST_STORE: begin
                if (cnt_zero) begin
                    r_d.st    = ST_INHIBIT;
                    r_d.dirty = 1'b0;
                end
            end
            default: begin
                r_d.st = ST_INHIBIT;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st    <= ST_INHIBIT;
            r_q.cnt   <= '0;
            r_q.dirty <= 1'b0;
            r_q.sp    <= 1'b0;
            r_q.rp    <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign state_o        = r_q.st;
    assign store_done_o   = (r_q.st == ST_STORE) && cnt_zero;
    assign store_pulse_o  = r_q.sp;
    assign recall_pulse_o = r_q.rp;

endmodule

// File: rtl/nvps_gate.sv
module nvps_gate
    import nvps_pkg::*;
(
    input  seq_state_e state_i,
    input  logic       supply_ok,
    input  logic       host_rd,
    input  logic       host_wr,
    output logic       mem_rd_en,
    output logic       mem_wr_en
);

    logic open_win;

    always_comb begin
        open_win  = ((state_i == ST_IDLE) && supply_ok) || (state_i == ST_GRACE);
        mem_rd_en = open_win && host_rd;
        mem_wr_en = open_win && host_wr;
    end

endmodule

// File: rtl/nvps_hsk.sv
module nvps_hsk #(
    parameter int unsigned HOLD_CYC = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_store,
    input  logic store_done,
    input  logic drv_supply_ok,
    output logic hsk_oe,
    output logic hsk_drv
);

    localparam int unsigned HW = $clog2(HOLD_CYC + 1);

    typedef struct packed {
        logic [HW-1:0] hold;
    } hsk_t;

    hsk_t h_d, h_q;

    always_comb begin
        h_d = h_q;
        if (store_done) begin
            h_d.hold = HW'(HOLD_CYC);
        end else if (h_q.hold != '0) begin
            h_d.hold = h_q.hold - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_q.hold <= '0;
        end else begin
            h_q <= h_d;
        end
    end

    assign hsk_oe  = drv_supply_ok && (in_store || (h_q.hold != '0));
    assign hsk_drv = !in_store;

endmodule

// File: rtl/nvsram_pwr_seq.sv
module nvsram_pwr_seq
    import nvps_pkg::*;
#(
    parameter int unsigned RECALL_CYC = 4000000,
    parameter int unsigned STORE_CYC  = 1600000,
    parameter int unsigned GRACE_CYC  = 5,
    parameter int unsigned HOLD_CYC   = 100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       supply_ok,
    input  logic       drv_supply_ok,
    input  logic       host_rd,
    input  logic       host_wr,
    output logic       mem_rd_en,
    output logic       mem_wr_en,
    output logic       hsk_oe,
    output logic       hsk_drv,
    output logic       store_pulse,
    output logic       recall_pulse,
    output logic [2:0] status
);

    seq_state_e state;
    logic       store_done;

    nvps_fsm #(
        .RECALL_CYC (RECALL_CYC),
        .STORE_CYC  (STORE_CYC),
        .GRACE_CYC  (GRACE_CYC)
    ) fsm_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .supply_ok      (supply_ok),
        .wr_taken       (mem_wr_en),
        .state_o        (state),
        .store_done_o   (store_done),
        .store_pulse_o  (store_pulse),
        .recall_pulse_o (recall_pulse)
    );

    nvps_gate gate_i (
        .state_i   (state),
        .supply_ok (supply_ok),
        .host_rd   (host_rd),
        .host_wr   (host_wr),
        .mem_rd_en (mem_rd_en),
        .mem_wr_en (mem_wr_en)
    );

    nvps_hsk #(
        .HOLD_CYC (HOLD_CYC)
    ) hsk_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_store      (state == ST_STORE),
        .store_done    (store_done),
        .drv_supply_ok (drv_supply_ok),
        .hsk_oe        (hsk_oe),
        .hsk_drv       (hsk_drv)
    );

    assign status = state;

endmodule

// File: rtl/nvps_checker.sv
module nvps_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       supply_ok,
    input logic       drv_supply_ok,
    input logic       host_rd,
    input logic       host_wr,
    input logic       mem_rd_en,
    input logic       mem_wr_en,
    input logic       hsk_oe,
    input logic       hsk_drv,
    input logic       store_pulse,
    input logic       recall_pulse,
    input logic [2:0] status
);

    AST_RESET_CLOSED: assert property (@(posedge clk) !rst_n |-> (!mem_rd_en && !mem_wr_en && !hsk_oe)); // R1

    AST_RECALL_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        recall_pulse |-> (status == 3'd1) && ($past(status) == 3'd4)); // R2

    AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 3'd0 && supply_ok) |-> (mem_rd_en == host_rd) && (mem_wr_en == host_wr)); // R3

    AST_ACCESS_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 3'd1 || status == 3'd3 || status == 3'd4) |-> (!mem_rd_en && !mem_wr_en)); // R4

    AST_STORE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        store_pulse |-> (status == 3'd3) && ($past(status) == 3'd2)); // R6

    AST_STORE_PULLS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 3'd3 && drv_supply_ok) |-> (hsk_oe && !hsk_drv)); // R8

    AST_DRIVER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !drv_supply_ok |-> !hsk_oe); // R10

    AST_STORE_NOT_CUT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(status) == 3'd3 && status != 3'd3) |-> (status == 3'd4)); // R11

    AST_STATE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        status <= 3'd4); // R12

endmodule

bind nvsram_pwr_seq nvps_checker chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .supply_ok     (supply_ok),
    .drv_supply_ok (drv_supply_ok),
    .host_rd       (host_rd),
    .host_wr       (host_wr),
    .mem_rd_en     (mem_rd_en),
    .mem_wr_en     (mem_wr_en),
    .hsk_oe        (hsk_oe),
    .hsk_drv       (hsk_drv),
    .store_pulse   (store_pulse),
    .recall_pulse  (recall_pulse),
    .status        (status)
);

// File: tb/nvsram_pwr_seq_tb_top.sv
`timescale 1ns/1ps
module nvsram_pwr_seq_tb_top;

    localparam int RECALL_N = 40;
    localparam int STORE_N  = 30;
    localparam int GRACE_N  = 5;
    localparam int HOLD_N   = 8;

    localparam int S_IDLE = 0, S_REC = 1, S_GRACE = 2, S_STORE = 3, S_INH = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b0;
    logic drv_supply_ok = 1'b1;
    logic host_rd = 1'b0;
    logic host_wr = 1'b0;
    logic mem_rd_en, mem_wr_en, hsk_oe, hsk_drv, store_pulse, recall_pulse;
    logic [2:0] status;

    int checks = 0;
    int errors = 0;
    bit rnd_rd = 0;
    bit rnd_wr = 0;
    bit finished = 0;
    int sp_seen = 0;
    int rp_seen = 0;

    // behavioural model
    int  m_state = S_INH;
    int  m_left  = 0;
    bit  m_dirty = 0;
    int  m_hold  = 0;
    bit  m_sp    = 0;
    bit  m_rp    = 0;

    always #2.5 clk = ~clk;

    nvsram_pwr_seq #(
        .RECALL_CYC (RECALL_N),
        .STORE_CYC  (STORE_N),
        .GRACE_CYC  (GRACE_N),
        .HOLD_CYC   (HOLD_N)
    ) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .supply_ok     (supply_ok),
        .drv_supply_ok (drv_supply_ok),
        .host_rd       (host_rd),
        .host_wr       (host_wr),
        .mem_rd_en     (mem_rd_en),
        .mem_wr_en     (mem_wr_en),
        .hsk_oe        (hsk_oe),
        .hsk_drv       (hsk_drv),
        .store_pulse   (store_pulse),
        .recall_pulse  (recall_pulse),
        .status        (status)
    );

    function automatic bit m_open();
        return (m_state == S_IDLE && supply_ok) || (m_state == S_GRACE);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_state = S_INH; m_left = 0; m_dirty = 0; m_hold = 0; m_sp = 0; m_rp = 0;
        end else begin
            bit wr_ok;
            wr_ok = host_wr && m_open();
            m_sp = 0;
            m_rp = 0;
            if (m_state == S_STORE && m_left == 1) m_hold = HOLD_N;
            else if (m_hold > 0) m_hold--;
            case (m_state)
                S_INH: if (supply_ok) begin m_state = S_REC; m_left = RECALL_N; m_rp = 1; end
                S_REC: begin
                    if (!supply_ok) m_state = S_INH;
                    else if (m_left == 1) begin m_state = S_IDLE; m_dirty = 0; end
                    else m_left--;
                end
                S_IDLE: begin
                    if (wr_ok) m_dirty = 1;
                    else if (!supply_ok) begin
                        if (m_dirty) begin m_state = S_GRACE; m_left = GRACE_N; end
                        else m_state = S_INH;
                    end
                end
                S_GRACE: begin
                    if (wr_ok) m_dirty = 1;
                    if (m_left == 1) begin m_state = S_STORE; m_left = STORE_N; m_sp = 1; end
                    else m_left--;
                end
                S_STORE: begin
                    if (m_left == 1) begin m_state = S_INH; m_dirty = 0; end
                    else m_left--;
                end
                default: m_state = S_INH;
            endcase
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        bit exp_oe;
        exp_oe = drv_supply_ok && (m_state == S_STORE || m_hold > 0);
        chk("R12 status", int'(status), m_state);
        chk(m_open() ? (m_state == S_GRACE ? "R6 rd" : "R3 rd") : "R4 rd",
            int'(mem_rd_en), int'(host_rd && m_open()));
        chk(m_open() ? (m_state == S_GRACE ? "R6 wr" : "R3 wr") : "R4 wr",
            int'(mem_wr_en), int'(host_wr && m_open()));
        chk(!drv_supply_ok ? "R10 oe" : (m_state == S_STORE ? "R8 oe" : "R9 oe"),
            int'(hsk_oe), int'(exp_oe));
        if (exp_oe) chk(m_state == S_STORE ? "R8 drv" : "R9 drv", int'(hsk_drv),
                        int'(m_state != S_STORE));
        chk("R6 store pulse", int'(store_pulse), int'(m_sp));
        chk("R2 recall pulse", int'(recall_pulse), int'(m_rp));
        if (store_pulse) sp_seen++;
        if (recall_pulse) rp_seen++;
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (rnd_rd) host_rd = 1'($urandom_range(0, 1));
            if (rnd_wr) host_wr = 1'($urandom_range(0, 1));
            #1;
            compare_all();
        end
    endtask

    initial begin
        #(5ns * 20000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual running expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int sp0, rp0;
        // R1: reset state with host strobes active
        host_rd = 1; host_wr = 1;
        repeat (3) @(negedge clk);
        #1;
        chk("R1 status", int'(status), S_INH);
        chk("R1 rd", int'(mem_rd_en), 0);
        chk("R1 wr", int'(mem_wr_en), 0);
        chk("R1 oe", int'(hsk_oe), 0);
        chk("R1 pulses", int'(store_pulse | recall_pulse), 0);
        rst_n = 1;
        step(5);

        // power-up recall, then clean power-down (R7)
        host_wr = 0; rnd_rd = 1;
        supply_ok = 1;
        step(RECALL_N + 15);
        chk("R2 idle after recall", int'(status), S_IDLE);
        sp0 = sp_seen;
        supply_ok = 0;
        step(12);
        chk("R7 no store when clean", sp_seen - sp0, 0);
        chk("R7 inhibited", int'(status), S_INH);

        // dirty power-down with driver supply dip (R5, R6, R8, R9, R10)
        supply_ok = 1; rnd_wr = 1;
        step(RECALL_N + 20);
        rnd_wr = 0; host_wr = 1;
        step(1);
        host_wr = 0; rnd_wr = 1;
        sp0 = sp_seen;
        supply_ok = 0;
        step(GRACE_N + 10);
        drv_supply_ok = 0;
        step(6);
        drv_supply_ok = 1;
        step(STORE_N + HOLD_N);
        chk("R5 dirty led to store", sp_seen - sp0, 1);

        // brown-out recovering during store (R11)
        supply_ok = 1;
        step(RECALL_N + 5);
        rnd_wr = 0; host_wr = 1;
        step(1);
        host_wr = 0;
        sp0 = sp_seen; rp0 = rp_seen;
        supply_ok = 0;
        step(GRACE_N + 4);
        supply_ok = 1;
        step(STORE_N + RECALL_N + 10);
        chk("R11 store then recall", (sp_seen - sp0) * 10 + (rp_seen - rp0), 11);
        chk("R11 idle after brown-out", int'(status), S_IDLE);

        // clean after completed recall (R5)
        sp0 = sp_seen;
        supply_ok = 0;
        step(10);
        chk("R5 clean after recall", sp_seen - sp0, 0);

        // supply lost during recall (R11), access attempts (R4)
        rnd_wr = 1;
        supply_ok = 1;
        step(10);
        supply_ok = 0;
        step(2);
        chk("R11 recall abandoned", int'(status), S_INH);
        supply_ok = 1;
        step(RECALL_N + 10);
        chk("R2 idle again", int'(status), S_IDLE);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule